// File: doc/BRIEF.md
# Four-Input Display Switch Port Select and Hot-Plug Control

This block is the control logic of a switch that feeds one of four display-link inputs to a single output. It decides which input is active and presents that choice as a one-hot vector. The same vector steers the DDC clock and data multiplexer, so the selected input's DDC pair connects to the downstream pair. The block drives the hot-plug level back to the selected input only, and it enables the input terminations of that input only. It also drives the enable of the output line driver.

The choice normally comes from two select pins and an output-enable pin. These pins are asynchronous, so each passes through a two-flop synchronizer. A software-mode bit makes the block ignore the pins and take the port and the output enable from register fields instead.

A new port takes effect only after its code has held steady for a programmable number of cycles, so short glitches on the select path are filtered out. An optional auto-powerdown turns off all terminations and the driver when the backend receiver shows no termination on its clock lane.

Top module: `port_switch_ctrl`

## Requirements
- R1: Select code 0 (binary 00) makes `port_onehot_o` equal 4'b0001 (port A), code 1 (01) gives 4'b0010 (B), code 2 (10) gives 4'b0100 (C), and code 3 (11) gives 4'b1000 (D). Bit p of `port_onehot_o` connects the DDC pair of port p to the downstream pair.
- R2: Bit p of `hpd_up_o` equals the synchronized `hpd_down_i` when port p is selected. Every unselected bit is 0.
- R3: Only the selected port's bit of `term_en_o` may be 1. At most one bit of `term_en_o` is ever set.
- R4: While `sw_mode_i` is 1, the port comes from `sw_sel_i` and the output enable from `sw_oe_i`. `sel_pin_i` and `oe_pin_i` then have no effect on any output.
- R5: `pwrdn_o` is 1 exactly when `apd_en_i` is 1 and the synchronized `rx_det_i` is 0. With `apd_en_i` at 0, `pwrdn_o` stays 0 whatever the value of `rx_det_i`.
- R6: `drv_en_o` is 0 whenever the effective output enable is 0 or `pwrdn_o` is 1. Otherwise it is 1.
- R7: While `pwrdn_o` is 1, `term_en_o` is 4'b0000.
- R8: In hardware mode, a new pin code appears on `port_onehot_o` at the (settle_i+4)-th rising clock edge after it is applied, and not before. A code held for fewer cycles than the settle window leaves `port_onehot_o` unchanged.
- R9: During reset, `port_onehot_o` is 4'b0001 and `term_en_o`, `hpd_up_o` and `drv_en_o` are all 0. After reset, the terminations enable from the first evaluation cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sel_pin_i | input | 2 | Select strap pins (asynchronous) |
| oe_pin_i | input | 1 | Output-enable strap pin (asynchronous) |
| hpd_down_i | input | 1 | Hot-plug level seen at the downstream output (asynchronous) |
| rx_det_i | input | 1 | Backend termination detected on the clock lane (asynchronous) |
| sw_mode_i | input | 1 | Software-mode register bit |
| sw_sel_i | input | 2 | Register-supplied port code |
| sw_oe_i | input | 1 | Register-supplied output enable |
| apd_en_i | input | 1 | Auto-powerdown enable register bit |
| settle_i | input | 8 | Number of stable cycles required before a port change applies |
| port_onehot_o | output | 4 | One-hot active port; also the DDC steering select |
| hpd_up_o | output | 4 | Hot-plug level returned to each input port |
| term_en_o | output | 4 | Input-termination enable for each port |
| drv_en_o | output | 1 | Output line-driver enable (0 puts the outputs in high impedance) |
| pwrdn_o | output | 1 | Powerdown indicator |

## Verification
The select path is tried with all four pin codes, each with the downstream hot-plug level both high and low. This shows that the decode, the hot-plug routing and the termination gating all follow the same port, and that no other port leaks a level. A code change is timed edge by edge, which separates a correct settle window from one that is off by one cycle. A two-cycle glitch separates a filter from a plain register. Software mode is checked by moving the pins to values that would give a different result, and powerdown is tried with each combination of the enable bit and the detect input, so that the detect input alone is shown to have no effect.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int unsigned NPORTS    = 4;
  localparam int unsigned SELW      = $clog2(NPORTS);
  localparam int unsigned SETTLE_W  = 8;
  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/psw_sync.sv
module psw_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d_i;
    for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= stg_d[s];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/psw_settle.sv
module psw_settle #(
  parameter int unsigned W  = 2,
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  cand_i,
  input  logic [CW-1:0] settle_i,
  output logic [W-1:0]  act_o
);
  logic [W-1:0]  last_q, last_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  act_q, act_d;
  logic          act_en;

  always_comb begin
    last_d = last_q;
    cnt_d  = cnt_q;
    act_en = 1'b0;
    if (cand_i != last_q) begin
      last_d = cand_i;
      cnt_d  = '0;
    end else if (cnt_q != settle_i) begin
      cnt_d  = cnt_q + 1'b1;
    end else begin
      act_en = 1'b1;
    end
    act_d = act_en ? last_q : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      cnt_q  <= '0;
      act_q  <= '0;
    end else begin
      last_q <= last_d;
      cnt_q  <= cnt_d;
      act_q  <= act_d;
    end
  end

  assign act_o = act_q;

  // R8: the active code moves only once its candidate has filled the window
  a_r8_change_after_window: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q != $past(act_q)) |-> ($past(cnt_q) == $past(settle_i) && $past(cand_i) == act_q));
endmodule

// File: rtl/port_switch_ctrl.sv
module port_switch_ctrl
  import psw_pkg::*;
#(
  parameter int unsigned N_PORTS = NPORTS,
  parameter int unsigned SW      = SELW,
  parameter int unsigned CW      = SETTLE_W,
  parameter int unsigned SYNC_N  = SYNC_DEPTH
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SW-1:0]      sel_pin_i,
  input  logic               oe_pin_i,
  input  logic               hpd_down_i,
  input  logic               rx_det_i,
  input  logic               sw_mode_i,
  input  logic [SW-1:0]      sw_sel_i,
  input  logic               sw_oe_i,
  input  logic               apd_en_i,
  input  logic [CW-1:0]      settle_i,
  output logic [N_PORTS-1:0] port_onehot_o,
  output logic [N_PORTS-1:0] hpd_up_o,
  output logic [N_PORTS-1:0] term_en_o,
  output logic               drv_en_o,
  output logic               pwrdn_o
);
  localparam int unsigned SYNCW = SW + 3;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  // asynchronous strap and status inputs
  logic [SYNCW-1:0] raw_pins, sync_pins;
  logic [SW-1:0]    sel_s;
  logic             oe_s, hpd_s, det_s;
  assign raw_pins = {sel_pin_i, oe_pin_i, hpd_down_i, rx_det_i};

  psw_sync #(.W(SYNCW), .STAGES(SYNC_N)) u_sync (
    .clk (clk), .rst_n (rst_s_n), .d_i (raw_pins), .q_o (sync_pins)
  );
  assign {sel_s, oe_s, hpd_s, det_s} = sync_pins;

  // register fields captured in this domain; reset forces hardware mode
  logic          mode_q, swoe_q, apd_q, valid_q;
  logic [SW-1:0] swsel_q;
  logic          mode_d, swoe_d, apd_d, valid_d;
  logic [SW-1:0] swsel_d;

  always_comb begin
    mode_d  = sw_mode_i;
    swsel_d = sw_sel_i;
    swoe_d  = sw_oe_i;
    apd_d   = apd_en_i;
    valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      mode_q  <= 1'b0;
      swsel_q <= '0;
      swoe_q  <= 1'b0;
      apd_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      swsel_q <= swsel_d;
      swoe_q  <= swoe_d;
      apd_q   <= apd_d;
      valid_q <= valid_d;
    end
  end

  // candidate selection and settle filter
  logic [SW-1:0] cand_sel, act_sel;
  logic          oe_eff;
  assign cand_sel = mode_q ? swsel_q : sel_s;
  assign oe_eff   = mode_q ? swoe_q  : oe_s;

  psw_settle #(.W(SW), .CW(CW)) u_settle (
    .clk (clk), .rst_n (rst_s_n), .cand_i (cand_sel),
    .settle_i (settle_i), .act_o (act_sel)
  );

  // per-port decode and gating
  logic pdn;
  assign pdn = apd_q & ~det_s;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    logic hit;
    assign hit              = (act_sel == SW'(p));
    assign port_onehot_o[p] = hit;
    assign hpd_up_o[p]      = valid_q & hit & hpd_s;
    assign term_en_o[p]     = valid_q & hit & ~pdn;
  end

  assign drv_en_o = valid_q & oe_eff & ~pdn;
  assign pwrdn_o  = pdn;

  // R3: at most one termination enabled
  a_r3_single_term: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0(term_en_o));
  // R2: hot-plug level never reaches an unselected port
  a_r2_hpd_selected_only: assert property (@(posedge clk) disable iff (!rst_s_n)
    (hpd_up_o & ~port_onehot_o) == '0);
  // R7: powerdown removes all terminations
  a_r7_pdn_no_term: assert property (@(posedge clk) disable iff (!rst_s_n)
    pwrdn_o |-> (term_en_o == '0 && !drv_en_o));
  // R1: termination follows the steered port
  a_r1_term_follows_port: assert property (@(posedge clk) disable iff (!rst_s_n)
    (term_en_o & ~port_onehot_o) == '0);
  // R4: in software mode the strap pins cannot move the port
  a_r4_sw_ignores_pins: assert property (@(posedge clk) disable iff (!rst_s_n)
    ($past(mode_q) && mode_q && $stable(swsel_q) && $past(act_sel) == $past(swsel_q))
      |-> $stable(port_onehot_o));
endmodule

// File: tb/port_switch_ctrl_tb_top.sv
module port_switch_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] sel_pin_i, sw_sel_i;
  logic       oe_pin_i, hpd_down_i, rx_det_i, sw_mode_i, sw_oe_i, apd_en_i;
  logic [7:0] settle_i;
  logic [3:0] port_onehot_o, hpd_up_o, term_en_o;
  logic       drv_en_o, pwrdn_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  port_switch_ctrl dut_i (
    .clk (clk), .rst_n (rst_n), .sel_pin_i (sel_pin_i), .oe_pin_i (oe_pin_i),
    .hpd_down_i (hpd_down_i), .rx_det_i (rx_det_i), .sw_mode_i (sw_mode_i),
    .sw_sel_i (sw_sel_i), .sw_oe_i (sw_oe_i), .apd_en_i (apd_en_i),
    .settle_i (settle_i), .port_onehot_o (port_onehot_o), .hpd_up_o (hpd_up_o),
    .term_en_o (term_en_o), .drv_en_o (drv_en_o), .pwrdn_o (pwrdn_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [3:0] dec(input logic [1:0] c);
    return 4'b0001 << c;
  endfunction

  task automatic t_reset;
    rst_n = 1'b0; sel_pin_i = 2'd2; oe_pin_i = 1'b1; hpd_down_i = 1'b1;
    rx_det_i = 1'b1; sw_mode_i = 1'b0; sw_sel_i = 2'd0; sw_oe_i = 1'b0;
    apd_en_i = 1'b0; settle_i = 8'd3;
    tick(3);
    chk("R9 onehot in reset", 8'(port_onehot_o), 8'h1);
    chk("R9 term in reset",   8'(term_en_o), 8'h0);
    chk("R9 hpd in reset",    8'(hpd_up_o), 8'h0);
    chk("R9 drv in reset",    8'(drv_en_o), 8'h0);
    sel_pin_i = 2'd0;
    rst_n = 1'b1;
    tick(6);
    chk("R9 term after reset", 8'(term_en_o), 8'h1);
  endtask

  task automatic t_hw_select;
    for (int c = 0; c < 4; c++) begin
      for (int h = 0; h < 2; h++) begin
        sel_pin_i = 2'(c); hpd_down_i = 1'(h);
        tick(20);
        chk("R1 onehot", 8'(port_onehot_o), 8'(dec(2'(c))));
        chk("R2 hpd",    8'(hpd_up_o), h ? 8'(dec(2'(c))) : 8'h0);
        chk("R3 term",   8'(term_en_o), 8'(dec(2'(c))));
      end
    end
  endtask

  task automatic t_settle;
    sel_pin_i = 2'd0; settle_i = 8'd3;
    tick(20);
    sel_pin_i = 2'd3;
    tick(6);
    chk("R8 before window", 8'(port_onehot_o), 8'h1);
    tick(1);
    chk("R8 at window", 8'(port_onehot_o), 8'h8);
    settle_i = 8'd5;
    tick(5);
    sel_pin_i = 2'd1;
    tick(2);
    sel_pin_i = 2'd3;
    tick(20);
    chk("R8 glitch ignored", 8'(port_onehot_o), 8'h8);
    settle_i = 8'd3;
  endtask

  task automatic t_oe;
    oe_pin_i = 1'b1; tick(6);
    chk("R6 drv on", 8'(drv_en_o), 8'h1);
    oe_pin_i = 1'b0; tick(6);
    chk("R6 drv off", 8'(drv_en_o), 8'h0);
    oe_pin_i = 1'b1; tick(6);
  endtask

  task automatic t_sw_mode;
    sel_pin_i = 2'd0; oe_pin_i = 1'b1; tick(20);
    sw_sel_i = 2'd2; sw_oe_i = 1'b0; sw_mode_i = 1'b1;
    tick(20);
    chk("R4 sw port", 8'(port_onehot_o), 8'h4);
    chk("R4 sw oe",   8'(drv_en_o), 8'h0);
    sel_pin_i = 2'd3; oe_pin_i = 1'b0; tick(20);
    chk("R4 pins ignored port", 8'(port_onehot_o), 8'h4);
    sw_oe_i = 1'b1; tick(5);
    chk("R4 sw oe on, pin low", 8'(drv_en_o), 8'h1);
    sw_mode_i = 1'b0; oe_pin_i = 1'b1; tick(20);
    chk("R4 back to pins", 8'(port_onehot_o), 8'h8);
  endtask

  task automatic t_powerdown;
    apd_en_i = 1'b0; rx_det_i = 1'b0; tick(6);
    chk("R5 no pdn when disabled", 8'(pwrdn_o), 8'h0);
    chk("R5 term kept", 8'(term_en_o), 8'h8);
    apd_en_i = 1'b1; tick(6);
    chk("R5 pdn asserted", 8'(pwrdn_o), 8'h1);
    chk("R7 term off", 8'(term_en_o), 8'h0);
    chk("R6 drv off in pdn", 8'(drv_en_o), 8'h0);
    rx_det_i = 1'b1; tick(6);
    chk("R5 pdn released", 8'(pwrdn_o), 8'h0);
    chk("R7 term back", 8'(term_en_o), 8'h8);
  endtask

  logic done = 1'b0;

  initial begin
    t_reset;
    t_hw_select;
    t_settle;
    t_oe;
    t_sw_mode;
    t_powerdown;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule